// File: doc/BRIEF.md
# Serial Flash Command Front End

This block is the device-side command decoder of a serial NOR flash. It watches a serial clock, an active-low select and a serial data input, all sampled by a faster system clock. It assembles an opcode, address, dummy and data bytes, and serves read-type commands by streaming bytes back on a serial output. For write-type commands it hands data bytes downstream as they arrive. At the end of the frame it issues a single command strobe, but only if the frame closed cleanly.

The block also owns two status bits: a write-enable latch and a busy flag. Busy is a programmable countdown started by every accepted program, erase or status-write command. While it runs, only the status read is served. Read bytes come from the array through a one-cycle request: `rd_req` is raised with the address on `addr`, and `rd_data` is taken in that same cycle.

Top module: `spi_cmd_front`

## Requirements
- R1: Serial input is taken on each rising `sclk` edge while `cs_n` is low, most significant bit first. The first eight bits form the opcode, and raising `cs_n` restarts the frame.
- R2: Opcode 03h takes a 3-byte address A, then returns on `miso` the bytes at A, A+1, ... (wrapping at 24 bits), most significant bit first. Each output bit changes after a falling `sclk` edge. Raising `cs_n` at any bit ends the frame cleanly. `miso` is 0 whenever no byte is being returned.
- R3: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address before data is returned.
- R4: Opcode 05h returns the status byte repeatedly, sampled afresh for each byte. Bit 0 is busy, bit 1 is the write-enable latch, and all other bits are 0.
- R5: Opcode 9Fh returns the identity bytes A5h, 3Ch, 17h in that order, then 00h for every later byte.
- R6: An accepted 06h sets the write-enable latch, and an accepted 04h clears it.
- R7: The write-type opcodes are 06h, 04h, C7h, B9h (minimum 8 bits), 01h (16), D8h (32) and 02h (40). One of them is accepted only if, when `cs_n` rises, the count of rising edges is a multiple of 8 and at least its minimum. Otherwise it has no effect.
- R8: Opcodes 02h, D8h, C7h and 01h also need the latch set. When accepted, `cmd_stb` pulses for one cycle with the opcode on `cmd_op` and the address on `addr`, the latch clears, and busy is held for BUSY_CYCLES cycles. An accepted B9h pulses `cmd_stb` without needing the latch.
- R9: `wdata_vld` pulses once per completed data byte, with the byte on `wdata`. This applies to the first PAGE data bytes after the address of 02h, and to the first data byte of 01h.
- R10: While busy, every opcode except 05h is ignored. There is no `rd_req`, no `cmd_stb`, no latch change, and `miso` stays 0.
- R11: An unknown opcode is ignored until `cs_n` rises. There is no strobe, no write byte, no read request, and `miso` stays 0.
- R12: After reset, `miso`, `cmd_stb`, `wdata_vld` and `rd_req` are 0, and both status bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cmd_stb | output | 1 | One-cycle pulse for an accepted write-type command |
| cmd_op | output | 8 | Opcode of the accepted command |
| addr | output | 24 | Command address; read address while `rd_req` is high |
| wdata | output | 8 | Received write byte |
| wdata_vld | output | 1 | Pulse marking a received write byte |
| rd_req | output | 1 | Request for the array byte at `addr` |
| rd_data | input | 8 | Array byte, taken in the cycle of `rd_req` |

## Verification
The busy countdown can expire in the middle of a running status-read stream, because each repeated status byte is sampled anew at its first falling edge. The bench starts a long 05h stream shortly after an accepted page program. It then requires the returned bytes to hold only 01h and 00h, to begin at 01h and end at 00h, and never to return to 01h after the first 00h. Frame closure at the instant of the final rising edge is a second overlap. Random bit counts around byte boundaries decide acceptance, and the bench compares each outcome with a count-based expectation.

// File: rtl/spi_cmd_front.sv
`timescale 1ns/1ps
module spi_cmd_front #(
  parameter int          PAGE        = 256,
  parameter int          BUSY_CYCLES = 4096,
  parameter int          CNT_W       = 13,
  parameter logic [23:0] ID_VAL      = 24'hA53C17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        cmd_stb,
  output logic [7:0]  cmd_op,
  output logic [23:0] addr,
  output logic [7:0]  wdata,
  output logic        wdata_vld,
  output logic        rd_req,
  input  logic [7:0]  rd_data
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] PP_LAST = CNT_W'(32 + 8 * PAGE);

  typedef enum logic [3:0] {
    K_NONE, K_WREN, K_WRDI, K_RDID, K_RDSR, K_WRSR,
    K_READ, K_FREAD, K_PP, K_SE, K_BE, K_DP
  } kind_t;

  logic             sclk_d, cs_d;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sr, op, nb, sh;
  kind_t            kind, dec, k_eff;
  logic             wel, pend, out_on;
  logic [BW-1:0]    busy_cnt;
  logic             busy;
  logic [2:0]       oidx;
  logic [1:0]       id_idx;
  logic [7:0]       src;

  wire              rise    = !cs_n && sclk && !sclk_d;
  wire              fall    = !cs_n && !sclk && sclk_d;
  wire              cs_up   = cs_n && !cs_d;
  wire [7:0]        byte_in = {sr[6:0], mosi};
  wire [CNT_W-1:0]  cnt_n   = (&cnt) ? cnt : cnt + 1'b1;

  assign busy   = |busy_cnt;
  assign k_eff  = (cnt == CNT_W'(7)) ? dec : kind;
  assign rd_req = pend && !cs_n && (kind == K_READ || kind == K_FREAD);

  function automatic logic [CNT_W-1:0] min_bits(kind_t k);
    case (k)
      K_WREN, K_WRDI, K_BE, K_DP: return CNT_W'(8);
      K_WRSR:                     return CNT_W'(16);
      K_SE:                       return CNT_W'(32);
      K_PP:                       return CNT_W'(40);
      default:                    return '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] hdr_bits(kind_t k);
    case (k)
      K_READ:         return CNT_W'(32);
      K_FREAD:        return CNT_W'(40);
      K_RDSR, K_RDID: return CNT_W'(8);
      default:        return '0;
    endcase
  endfunction

  function automatic logic needs_wel(kind_t k);
    return k == K_PP || k == K_SE || k == K_BE || k == K_WRSR;
  endfunction

  wire is_wr  = min_bits(kind) != '0;
  wire accept = is_wr && cnt[2:0] == 3'd0 && cnt >= min_bits(kind) &&
                (!needs_wel(kind) || wel);

  always_comb begin
    case (byte_in)
      8'h06:   dec = K_WREN;
      8'h04:   dec = K_WRDI;
      8'h9F:   dec = K_RDID;
      8'h05:   dec = K_RDSR;
      8'h01:   dec = K_WRSR;
      8'h03:   dec = K_READ;
      8'h0B:   dec = K_FREAD;
      8'h02:   dec = K_PP;
      8'hD8:   dec = K_SE;
      8'hC7:   dec = K_BE;
      8'hB9:   dec = K_DP;
      default: dec = K_NONE;
    endcase
    if (busy && dec != K_RDSR) dec = K_NONE;
  end

  always_comb begin
    case (kind)
      K_RDSR:  src = {6'b0, wel, busy};
      K_RDID:
        case (id_idx)
          2'd0:    src = ID_VAL[23:16];
          2'd1:    src = ID_VAL[15:8];
          2'd2:    src = ID_VAL[7:0];
          default: src = 8'h00;
        endcase
      default: src = rd_data;
    endcase
  end

  // frame side: shift-in, address, data-out stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; cs_d <= 1'b1; cnt <= '0; sr <= '0; op <= '0;
      kind <= K_NONE; addr <= '0; pend <= 1'b0; out_on <= 1'b0;
      nb <= '0; sh <= '0; oidx <= '0; id_idx <= '0; miso <= 1'b0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (cs_n) begin
        cnt <= '0; kind <= K_NONE; pend <= 1'b0; out_on <= 1'b0;
        oidx <= '0; id_idx <= '0; miso <= 1'b0;
      end else begin
        if (pend) begin
          pend <= 1'b0;
          nb   <= src;
          if (kind == K_READ || kind == K_FREAD) addr <= addr + 1'b1;
          if (kind == K_RDID && id_idx != 2'd3) id_idx <= id_idx + 1'b1;
        end
        if (rise) begin
          cnt <= cnt_n;
          sr  <= byte_in;
          if (cnt == CNT_W'(7)) begin
            kind <= dec;
            op   <= byte_in;
          end
          if (cnt >= CNT_W'(8) && cnt < CNT_W'(32) &&
              (kind == K_READ || kind == K_FREAD || kind == K_PP || kind == K_SE))
            addr <= {addr[22:0], mosi};
          if (hdr_bits(k_eff) != '0 && cnt_n == hdr_bits(k_eff)) begin
            out_on <= 1'b1;
            pend   <= 1'b1;
          end
        end
        if (fall && out_on) begin
          if (oidx == 3'd0) begin
            miso <= nb[7];
            sh   <= {nb[6:0], 1'b0};
            pend <= 1'b1;
          end else begin
            miso <= sh[7];
            sh   <= {sh[6:0], 1'b0};
          end
          oidx <= oidx + 1'b1;
        end
      end
    end
  end

  // command side: write bytes, acceptance, status bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb <= 1'b0; cmd_op <= '0; wdata <= '0; wdata_vld <= 1'b0;
      wel <= 1'b0; busy_cnt <= '0;
    end else begin
      cmd_stb   <= 1'b0;
      wdata_vld <= 1'b0;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (rise && cnt_n[2:0] == 3'd0 &&
          ((kind == K_PP && cnt_n >= CNT_W'(40) && cnt_n <= PP_LAST) ||
           (kind == K_WRSR && cnt_n == CNT_W'(16)))) begin
        wdata     <= byte_in;
        wdata_vld <= 1'b1;
      end
      if (cs_up && accept) begin
        cmd_stb <= 1'b1;
        cmd_op  <= op;
        if (kind == K_WREN) wel <= 1'b1;
        if (kind == K_WRDI) wel <= 1'b0;
        if (needs_wel(kind)) begin
          wel      <= 1'b0;
          busy_cnt <= BW'(BUSY_CYCLES);
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_front_chk.sv
`timescale 1ns/1ps
module spi_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso,
  input logic       cmd_stb,
  input logic [7:0] cmd_op,
  input logic       wdata_vld,
  input logic       rd_req,
  input logic       wel,
  input logic       busy
);
  p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !miso);

  p_stb_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(cs_n));

  p_stb_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  p_wel_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && (cmd_op == 8'h02 || cmd_op == 8'hD8 || cmd_op == 8'hC7 || cmd_op == 8'h01))
    |-> (!wel && busy));

  p_wbyte_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_vld |=> !wdata_vld);

  p_no_read_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !busy);
endmodule

bind spi_cmd_front spi_cmd_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .cmd_stb(cmd_stb),
  .cmd_op(cmd_op), .wdata_vld(wdata_vld), .rd_req(rd_req), .wel(wel), .busy(busy)
);

// File: tb/spi_cmd_front_tb.sv
`timescale 1ns/1ps
module spi_cmd_front_tb_top;
  localparam int BUSY = 1500;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, cmd_stb, wdata_vld, rd_req;
  logic [7:0] cmd_op, wdata, rd_data;
  logic [23:0] addr;

  int vec = 0, errs = 0;
  int stb_n = 0, rdq_n = 0, w_n = 0;
  logic [7:0]  last_op = '0;
  logic [23:0] last_addr = '0;
  logic [7:0]  wbuf [0:299];
  logic [7:0]  tx   [0:299];
  logic        rxb  [0:2399];

  always #2.5 clk = ~clk;

  spi_cmd_front #(.PAGE(4), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .addr(addr), .wdata(wdata),
    .wdata_vld(wdata_vld), .rd_req(rd_req), .rd_data(rd_data));

  function automatic logic [7:0] memb(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction
  assign rd_data = memb(addr);

  always @(posedge clk) begin
    if (cmd_stb) begin stb_n <= stb_n + 1; last_op <= cmd_op; last_addr <= addr; end
    if (rd_req) rdq_n <= rdq_n + 1;
    if (wdata_vld) begin
      if (w_n < 300) wbuf[w_n] <= wdata;
      w_n <= w_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clr_tx();
    for (int i = 0; i < 300; i++) tx[i] = 8'h00;
  endtask

  task automatic txn(input int nbits);
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[i / 8][7 - (i % 8)];
      repeat (4) @(negedge clk);
      rxb[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [7:0] rxbyte(input int k);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) b[7 - j] = rxb[8 * k + j];
    return b;
  endfunction

  task automatic op1(input logic [7:0] o, input int nbits);
    clr_tx(); tx[0] = o; txn(nbits);
  endtask

  task automatic rdsr(output logic [7:0] s);
    op1(8'h05, 16); s = rxbyte(1);
  endtask

  task automatic set_a(input logic [23:0] a);
    tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
  endtask

  task automatic wait_busy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog all-R act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end

  initial begin
    logic [7:0] s, d0, prev;
    logic [23:0] a;
    int n, st0, w0, r0, len, hb;
    bit seen0, bad;
    void'($urandom(32'd4711));

    repeat (5) @(negedge clk);
    chk("R12 miso", miso, 0);
    chk("R12 cmd_stb", cmd_stb, 0);
    chk("R12 wdata_vld", wdata_vld, 0);
    chk("R12 rd_req", rd_req, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    op1(8'h05, 40);
    for (int k = 1; k < 5; k++) chk("R12 R4 status after reset", rxbyte(k), 8'h00);

    op1(8'h9F, 48);
    chk("R5 id0", rxbyte(1), 8'hA5);
    chk("R5 id1", rxbyte(2), 8'h3C);
    chk("R5 id2", rxbyte(3), 8'h17);
    chk("R5 id pad", rxbyte(4), 8'h00);
    chk("R5 id pad2", rxbyte(5), 8'h00);

    clr_tx(); tx[0] = 8'h03; set_a(24'hFFFFFE); txn(64);
    for (int k = 0; k < 4; k++) chk("R2 wrap", rxbyte(4 + k), memb(24'hFFFFFE + 24'(k)));

    // R1 R2 R3 random reads, cut at random bit positions
    for (int t = 0; t < 10; t++) begin
      a = 24'($urandom);
      len = 1 + int'($urandom % 6);
      hb = ($urandom % 2) ? 5 : 4;
      clr_tx(); tx[0] = (hb == 5) ? 8'h0B : 8'h03; set_a(a); tx[4] = 8'($urandom);
      txn(8 * (hb + len) + int'($urandom % 8));
      for (int k = 0; k < len; k++)
        chk(hb == 5 ? "R3 fast read" : "R1 R2 read", rxbyte(hb + k), memb(a + 24'(k)));
    end
    rdsr(s); chk("R2 clean end", s, 8'h00);

    st0 = stb_n; w0 = w_n; r0 = rdq_n;
    clr_tx(); tx[0] = 8'h5A; tx[1] = 8'h02; txn(32);
    bad = 0;
    for (int i = 0; i < 32; i++) if (rxb[i]) bad = 1;
    chk("R11 miso", bad, 0);
    chk("R11 stb", stb_n, st0);
    chk("R11 wbytes", w_n, w0);
    chk("R11 rdreq", rdq_n, r0);

    op1(8'h06, 8); rdsr(s); chk("R6 wren", s, 8'h02);
    op1(8'h04, 12); rdsr(s); chk("R7 wrdi off boundary", s, 8'h02);
    op1(8'h04, 8); rdsr(s); chk("R6 wrdi", s, 8'h00);

    for (int t = 0; t < 8; t++) begin
      n = 1 + int'($urandom % 24);
      op1(8'h06, n); rdsr(s);
      chk("R7 boundary rule", s[1], (n % 8) == 0);
      op1(8'h04, 8);
    end

    st0 = stb_n;
    clr_tx(); tx[0] = 8'h02; set_a(24'h001234); tx[4] = 8'h77; txn(40);
    chk("R8 pp needs wel", stb_n, st0);

    op1(8'h06, 8);
    st0 = stb_n; w0 = w_n;
    clr_tx(); tx[0] = 8'h02; set_a(24'h00ABCD);
    for (int k = 0; k < 3; k++) tx[4 + k] = 8'($urandom);
    txn(8 * 7 + 5);
    chk("R7 pp partial", stb_n, st0);
    chk("R9 partial bytes", w_n, w0 + 3);
    rdsr(s); chk("R7 wel kept", s, 8'h02);

    a = 24'($urandom);
    n = 1 + int'($urandom % 4);
    st0 = stb_n; w0 = w_n;
    clr_tx(); tx[0] = 8'h02; set_a(a);
    for (int k = 0; k < n; k++) tx[4 + k] = 8'($urandom);
    txn(8 * (4 + n));
    chk("R8 pp strobe", stb_n, st0 + 1);
    chk("R8 pp op", last_op, 8'h02);
    chk("R8 pp addr", last_addr, a);
    chk("R9 pp count", w_n, w0 + n);
    for (int k = 0; k < n; k++) chk("R9 pp data", wbuf[w0 + k], tx[4 + k]);
    rdsr(s); chk("R8 R4 busy status", s, 8'h01);

    r0 = rdq_n; st0 = stb_n;
    clr_tx(); tx[0] = 8'h03; set_a(24'h000100); txn(48);
    chk("R10 read data", {rxbyte(4), rxbyte(5)}, 16'h0000);
    chk("R10 no rdreq", rdq_n, r0);
    op1(8'h06, 8); rdsr(s);
    chk("R10 wren ignored", s, 8'h01);
    chk("R10 no strobe", stb_n, st0);

    op1(8'h05, 8 * 41);
    prev = 8'h01; seen0 = 0; bad = 0;
    for (int k = 1; k <= 40; k++) begin
      d0 = rxbyte(k);
      if (d0 != 8'h00 && d0 != 8'h01) bad = 1;
      if (d0 == 8'h00) seen0 = 1;
      if (seen0 && d0 == 8'h01) bad = 1;
      prev = d0;
    end
    chk("R4 R10 stream first", rxbyte(1), 8'h01);
    chk("R4 R10 stream last", prev, 8'h00);
    chk("R4 R10 stream monotone", bad, 0);

    op1(8'h06, 8);
    w0 = w_n;
    clr_tx(); tx[0] = 8'h02; set_a(24'h000040);
    for (int k = 0; k < 6; k++) tx[4 + k] = 8'(k + 8'h90);
    txn(80);
    chk("R9 page limit", w_n, w0 + 4);
    chk("R9 page last", wbuf[w0 + 3], 8'h93);
    chk("R8 long pp op", last_op, 8'h02);
    wait_busy();

    op1(8'h06, 8);
    st0 = stb_n; w0 = w_n; d0 = 8'($urandom);
    clr_tx(); tx[0] = 8'h01; tx[1] = d0; tx[2] = 8'hEE; txn(24);
    chk("R8 wrsr op", last_op, 8'h01);
    chk("R9 wrsr count", w_n, w0 + 1);
    chk("R9 wrsr data", wbuf[w0], d0);
    wait_busy();

    op1(8'h06, 8);
    st0 = stb_n;
    clr_tx(); tx[0] = 8'hD8; set_a(24'h123456); txn(24);
    chk("R7 se short", stb_n, st0);
    a = 24'($urandom);
    clr_tx(); tx[0] = 8'hD8; set_a(a); txn(32);
    chk("R8 se op", last_op, 8'hD8);
    chk("R8 se addr", last_addr, a);
    wait_busy();

    op1(8'h06, 8); op1(8'hC7, 8);
    chk("R8 be op", last_op, 8'hC7);
    rdsr(s); chk("R8 be busy", s, 8'h01);
    wait_busy();

    st0 = stb_n;
    op1(8'hB9, 8);
    chk("R8 dp strobe", stb_n, st0 + 1);
    chk("R8 dp op", last_op, 8'hB9);
    rdsr(s); chk("R8 dp status", s, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vec, errs);
    $finish;
  end
endmodule